// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block produces the access address for a burst of four beats. A load command captures an external address as the burst start. Each later advance command steps only the two lowest address bits. The upper bits stay where the load put them. The low bits follow one of two orders, chosen by a mode input: a counting order (start plus beat number, modulo four) or an exclusive-or order (start XOR beat number).

The block sits in front of a memory address register. A single control pin chooses between the two commands. When that pin is low, the block loads. When it is high, the block advances, whatever the chip-select or write state of the surrounding logic. An active-low clock enable qualifies every edge. When the clock enable is inactive, the edge is ignored and all state is held.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addrOut is all zeros, and the burst start and beat count are zero.
- R2: At a rising edge with clkEnN low and advNotLoad low, addrIn is captured and appears on addrOut from the next cycle. The beat count restarts at zero.
- R3: With interleave low, the advance that makes the beat count n drives the two low bits to (start low bits + n) mod 4.
- R4: With interleave high, the advance that makes the beat count n drives the two low bits to (start low bits) XOR n.
- R5: The address bits above bit 1 do not change on any advance.
- R6: The beat count wraps modulo 4. The fourth advance after a load returns the low bits to the start value, with no carry into bit 2.
- R7: At a rising edge with clkEnN high, addrOut and all internal state are held, whatever advNotLoad, interleave and addrIn are.
- R8: The interleave input is sampled at every advance. Changing it in the middle of a burst applies the new order to the current start and beat count.
- R9: A load in the middle of a burst replaces the start address and restarts the beat count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; when high the edge is ignored |
| advNotLoad | input | 1 | 0 = load addrIn as burst start, 1 = advance the burst |
| interleave | input | 1 | 0 = linear order, 1 = XOR order |
| addrIn | input | ADDR_W (17) | External start address |
| addrOut | output | ADDR_W (17) | Current access address |

## Verification
The assertions check four properties on every cycle:
- a disabled edge leaves the address unchanged;
- a load places the captured address on the output;
- an advance never disturbs the upper bits;
- the advance that wraps the beat count lands back on the start bits.

The exact values of each order, a mode switch in the middle of a burst, and a reload in the middle of a burst depend on the history since the last load. Only the bench's per-cycle reference model can show those, across the directed and mixed stimulus phases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LOW_W = 2;
  localparam int BEATS = 1 << LOW_W;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobeT;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic             advNotLoad,
  output seqStrobeT        strb,
  output logic [LOW_W-1:0] beatNext
);
  logic [LOW_W-1:0] beatQ;

  always_comb begin
    strb.load    = !clkEnN && !advNotLoad;
    strb.advance = !clkEnN && advNotLoad;
    beatNext     = beatQ + LOW_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              beatQ <= '0;
    else if (strb.load)     beatQ <= '0;
    else if (strb.advance)  beatQ <= beatNext;
  end

  // R7: a disabled edge keeps the beat count
  a_r7_beat_hold: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(beatQ));
endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [LOW_W-1:0]  beatNext,
  input  logic              interleave,
  input  logic              clkEnN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UP_W = ADDR_W - LOW_W;

  logic [UP_W-1:0]  upperQ;
  logic [LOW_W-1:0] baseQ;
  logic [LOW_W-1:0] lowQ;
  logic [LOW_W-1:0] stepLow;

  generate
    for (genvar b = 0; b < LOW_W; b++) begin : g_xorBit
      logic linBit;
      logic [LOW_W-1:0] linSum;
      assign linSum = baseQ + beatNext;
      assign linBit = linSum[b];
      assign stepLow[b] = interleave ? (baseQ[b] ^ beatNext[b]) : linBit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      baseQ  <= '0;
      lowQ   <= '0;
    end else if (strb.load) begin
      upperQ <= addrIn[ADDR_W-1:LOW_W];
      baseQ  <= addrIn[LOW_W-1:0];
      lowQ   <= addrIn[LOW_W-1:0];
    end else if (strb.advance) begin
      lowQ   <= stepLow;
    end
  end

  assign addrOut = {upperQ, lowQ};

  // R7: disabled edge holds the address
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(addrOut));
  // R2: load places the captured address on the output
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> addrOut == $past(addrIn));
  // R5: upper bits untouched by an advance
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> addrOut[ADDR_W-1:LOW_W] == $past(addrOut[ADDR_W-1:LOW_W]));
  // R6: the wrapping advance returns to the start bits
  a_r6_wrap_start: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && beatNext == '0) |=> addrOut[LOW_W-1:0] == baseQ);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advNotLoad,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  seqStrobeT        strb;
  logic [LOW_W-1:0] beatNext;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEnN     (clkEnN),
    .advNotLoad (advNotLoad),
    .strb       (strb),
    .beatNext   (beatNext)
  );

  burst_seq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .beatNext   (beatNext),
    .interleave (interleave),
    .clkEnN     (clkEnN),
    .addrIn     (addrIn),
    .addrOut    (addrOut)
  );
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int ADDR_W = 17;

  logic              clk = 0;
  logic              rstN = 0;
  logic              clkEnN = 1;
  logic              advNotLoad = 0;
  logic              interleave = 0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0;
  int fails  = 0;
  int startAddr = 0;
  int beatN = 0;
  int expAddr = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advNotLoad(advNotLoad),
    .interleave(interleave), .addrIn(addrIn), .addrOut(addrOut));

  task automatic check(string tag);
    checks++;
    if (addrOut !== ADDR_W'(expAddr)) begin
      fails++;
      $display("FAIL %s: addrOut=%h expected=%h", tag, addrOut, ADDR_W'(expAddr));
    end
  endtask

  // one clock: drive at negedge, update model at the edge, compare after it
  task automatic cyc(input logic en_n, input logic adv, input logic md,
                     input int addr, input string tag);
    @(negedge clk);
    clkEnN = en_n; advNotLoad = adv; interleave = md; addrIn = ADDR_W'(addr);
    @(posedge clk);
    if (!en_n) begin
      if (!adv) begin
        startAddr = addr & ((1 << ADDR_W) - 1);
        beatN = 0;
        expAddr = startAddr;
      end else begin
        beatN = (beatN + 1) % 4;
        if (md) expAddr = (startAddr & ~3) | ((startAddr & 3) ^ beatN);
        else    expAddr = (startAddr & ~3) | (((startAddr & 3) + beatN) % 4);
      end
    end
    #2;
    check(tag);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expAddr = 0;
    check("R1 reset");
    rstN = 1;
    @(negedge clk);
    check("R1 after release");

    // R2 load, R3 linear walk with wrap (R6)
    cyc(0, 0, 0, 'h1ABC6, "R2 load");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, "R3 R5 R6 linear");
    // R4 interleaved
    cyc(0, 0, 1, 'h0F0F1, "R2 load");
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 'h3, "R4 R6 interleave");
    cyc(0, 0, 1, 'h12343, "R2 load");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, "R4 R5 interleave");
    // R7 hold with advance, load and mode flips requested
    cyc(1, 1, 0, 'h1FFFF, "R7 hold adv");
    cyc(1, 0, 1, 'h1FFFF, "R7 hold load");
    cyc(0, 1, 1, 0, "R7 count kept");
    // R8 mode switch mid burst
    cyc(0, 0, 0, 'h00016, "R2 load");
    cyc(0, 1, 0, 0, "R8 linear beat");
    cyc(0, 1, 1, 0, "R8 switch to xor");
    cyc(0, 1, 0, 0, "R8 back to linear");
    // R9 reload mid burst
    cyc(0, 1, 0, 0, "R6 wrap");
    cyc(0, 1, 0, 0, "R3 step");
    cyc(0, 0, 0, 'h0AAA1, "R9 reload");
    cyc(0, 1, 0, 0, "R9 restarted count");
    // mixed pattern
    for (int i = 0; i < 300; i++) begin
      int r = (i * 37 + 11) % 97;
      cyc(logic'((r % 7) == 0), logic'((r % 5) != 0), logic'((i / 9) % 2),
          (i * 4729 + 13) % (1 << ADDR_W), "R2 R3 R4 R7 R8 mixed");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule